// File: doc/BRIEF.md
# Clock-Crossing Converter Control Register

This block holds the 8-bit control word of a converter peripheral. Software reaches it through a simple write/read port clocked by the bus clock. The converter core runs on a separate core clock. The enable bit and the soft-reset request reach the core through a toggle handshake. Each has a busy flag that stays high until the core has acknowledged the change.

A bus write is accepted when `wr_en` and `wr_ready` are both high and `lock` is low. `wr_ready` drops while either busy flag is set, so a second write waits until the earlier crossing has finished.

In the core domain the block drives one registered `core_run` output. It is computed from the synchronized enable, the on-demand and run-in-standby bits, a peripheral request input and a standby input.

Top module: `cvt_ctrl_reg`

## Requirements
- R1: After reset `rd_data` reads 0x00, both busy flags are low, `wr_ready` is high and `core_run` is low.
- R2: Bits 5 down to 2 of `rd_data` always read 0; writing ones to them changes nothing.
- R3: An accepted write with bit 0 low loads bit 7 (on-demand), bit 6 (run-in-standby) and bit 1 (enable), and these read back one bus cycle later. If bit 1 differs from the stored enable, `busy_en` rises in that same cycle.
- R4: `busy_en` stays high for at least two bus cycles after it rises. When it falls, the core has already adopted the new enable, and `core_run` follows within a few core cycles.
- R5: An accepted write with bit 0 high sets bit 0 and `busy_rst` and leaves bits 7, 6 and 1 unchanged, whatever the other written bits are.
- R6: Bit 0 of `rd_data` always equals `busy_rst`. When the core has finished the soft reset, both clear in the same cycle and the register reads 0x00. The core is then disabled and `core_run` is low.
- R7: A write with bit 0 low starts no soft reset.
- R8: While `lock` is high, writes change neither `rd_data` nor the busy flags.
- R9: `wr_ready` is low while either busy flag is set.
- R10: With on-demand 0 and not in standby, an enabled core runs continuously, independent of `periph_req`.
- R11: With on-demand 1, an enabled core runs only while `periph_req` is high.
- R12: With `standby` high, the core halts if run-in-standby is 0. If run-in-standby is 1, the on-demand rule of R10/R11 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Bus-domain synchronous reset, active high |
| cclk | input | 1 | Core clock |
| crst | input | 1 | Core-domain synchronous reset, active high |
| lock | input | 1 | Write protection; writes are dropped while high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wr_ready | output | 1 | High when a write can be accepted |
| rd_data | output | 8 | Current register value |
| busy_en | output | 1 | Enable change still crossing to the core |
| busy_rst | output | 1 | Soft reset still in progress |
| periph_req | input | 1 | Peripheral request for a conversion (core domain) |
| standby | input | 1 | Device is in standby (core domain) |
| core_run | output | 1 | Registered core run permission (core domain) |

## Verification
The bench walks all the interesting combinations of on-demand, run-in-standby, standby and request. A swapped or missing gating term would therefore raise `core_run` in a case where it must stay low, or the reverse.

It writes a soft reset together with ones in every other bit. A design that did not discard those bits would show them in the readback. A design that cleared the register before the handshake returned would drop bit 0 ahead of `busy_rst`.

It also checks that `busy_en` is still high and `core_run` still low just after an enable write. A design that skipped the handshake would clear the flag or start the core too early.

Locked writes, writes to the reserved bits and writes with bit 0 low are each followed by a readback. Any of them that reached the register would change a bit that must stay put.

// File: rtl/cvt_ctrl_pkg.sv
package cvt_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int B_OD   = 7;  // on-demand
  localparam int B_RS   = 6;  // run in standby
  localparam int B_EN   = 1;  // enable
  localparam int B_SR   = 0;  // soft reset
  localparam int NUM_CH = 2;
  localparam int CH_EN  = 0;
  localparam int CH_SR  = 1;
endpackage

// File: rtl/cvt_sync_ff.sv
module cvt_sync_ff #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cvt_toggle_link.sv
module cvt_toggle_link #(
  parameter int STAGES = 2
) (
  input  logic bclk,
  input  logic brst,
  input  logic launch,   // bus domain, one-cycle pulse
  output logic done,     // bus domain, one-cycle pulse on acknowledge
  input  logic cclk,
  input  logic crst,
  output logic fire      // core domain, one-cycle pulse on request
);
  logic req_t, req_s, req_seen;
  logic ack_t, ack_s, ack_seen;

  // bus side: launch toggles the request, returned toggle ends it
  always_ff @(posedge bclk) begin
    if (brst) begin
      req_t    <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      req_t    <= req_t ^ launch;
      ack_seen <= ack_s;
    end
  end

  cvt_sync_ff #(.STAGES(STAGES)) u_ack_sync (
    .clk(bclk), .rst(brst), .d(ack_t), .q(ack_s)
  );
  assign done = ack_s ^ ack_seen;

  // core side: detect request toggle, act and return it
  cvt_sync_ff #(.STAGES(STAGES)) u_req_sync (
    .clk(cclk), .rst(crst), .d(req_t), .q(req_s)
  );
  assign fire = req_s ^ req_seen;

  always_ff @(posedge cclk) begin
    if (crst) begin
      req_seen <= 1'b0;
      ack_t    <= 1'b0;
    end else begin
      req_seen <= req_s;
      ack_t    <= ack_t ^ fire;
    end
  end
endmodule

// File: rtl/cvt_run_gate.sv
module cvt_run_gate (
  input  logic cclk,
  input  logic crst,
  input  logic fire_en,
  input  logic fire_sr,
  input  logic en_bus,     // held stable by the bus side while busy
  input  logic ondemand,
  input  logic runstdby,
  input  logic periph_req,
  input  logic standby,
  output logic core_run
);
  logic core_en;

  always_ff @(posedge cclk) begin
    if (crst) begin
      core_en  <= 1'b0;
      core_run <= 1'b0;
    end else begin
      if (fire_sr)      core_en <= 1'b0;
      else if (fire_en) core_en <= en_bus;
      core_run <= core_en & (~ondemand | periph_req) & (~standby | runstdby);
    end
  end
endmodule

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
  import cvt_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             bclk,
  input  logic             brst,
  input  logic             cclk,
  input  logic             crst,
  input  logic             lock,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             wr_ready,
  output logic [REG_W-1:0] rd_data,
  output logic             busy_en,
  output logic             busy_rst,
  input  logic             periph_req,
  input  logic             standby,
  output logic             core_run
);
  logic od_q, rs_q, en_q, sr_q;
  logic accept;
  logic [NUM_CH-1:0] launch, done, fire;
  logic unused_rsvd;

  assign unused_rsvd = ^wr_data[B_RS-1:B_EN+1];
  assign wr_ready    = ~(busy_en | busy_rst);
  assign accept      = wr_en & wr_ready & ~lock;

  assign launch[CH_SR] = accept & wr_data[B_SR];
  assign launch[CH_EN] = accept & ~wr_data[B_SR] & (wr_data[B_EN] != en_q);

  always_ff @(posedge bclk) begin
    if (brst) begin
      od_q     <= 1'b0;
      rs_q     <= 1'b0;
      en_q     <= 1'b0;
      sr_q     <= 1'b0;
      busy_en  <= 1'b0;
      busy_rst <= 1'b0;
    end else begin
      if (done[CH_EN]) busy_en <= 1'b0;
      if (done[CH_SR]) begin
        od_q     <= 1'b0;
        rs_q     <= 1'b0;
        en_q     <= 1'b0;
        sr_q     <= 1'b0;
        busy_rst <= 1'b0;
      end
      if (accept) begin
        if (wr_data[B_SR]) begin
          sr_q     <= 1'b1;
          busy_rst <= 1'b1;
        end else begin
          od_q <= wr_data[B_OD];
          rs_q <= wr_data[B_RS];
          en_q <= wr_data[B_EN];
          if (launch[CH_EN]) busy_en <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data       = '0;
    rd_data[B_OD] = od_q;
    rd_data[B_RS] = rs_q;
    rd_data[B_EN] = en_q;
    rd_data[B_SR] = sr_q;
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_link
      cvt_toggle_link #(.STAGES(SYNC_STAGES)) u_link (
        .bclk(bclk), .brst(brst), .launch(launch[ch]), .done(done[ch]),
        .cclk(cclk), .crst(crst), .fire(fire[ch])
      );
    end
  endgenerate

  cvt_run_gate u_gate (
    .cclk(cclk), .crst(crst),
    .fire_en(fire[CH_EN]), .fire_sr(fire[CH_SR]),
    .en_bus(en_q), .ondemand(od_q), .runstdby(rs_q),
    .periph_req(periph_req), .standby(standby),
    .core_run(core_run)
  );
endmodule

// File: rtl/cvt_ctrl_reg_chk.sv
module cvt_ctrl_reg_chk (
  input logic       bclk,
  input logic       brst,
  input logic       cclk,
  input logic       crst,
  input logic       lock,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       busy_en,
  input logic       busy_rst,
  input logic       periph_req,
  input logic       standby,
  input logic       core_run
);
  a_r2_rsvd_zero: assert property (@(posedge bclk) disable iff (brst)
    rd_data[5:2] == 4'b0000);

  a_r3_readback: assert property (@(posedge bclk) disable iff (brst)
    (wr_en && wr_ready && !lock && !wr_data[0]) |=>
      (rd_data[1] == $past(wr_data[1]) && rd_data[7:6] == $past(wr_data[7:6])));

  a_r5_sr_discard: assert property (@(posedge bclk) disable iff (brst)
    (wr_en && wr_ready && !lock && wr_data[0]) |=>
      (busy_rst && rd_data[0] && rd_data[7:1] == $past(rd_data[7:1])));

  a_r6_sr_pair: assert property (@(posedge bclk) disable iff (brst)
    rd_data[0] == busy_rst);

  a_r6_sr_clear: assert property (@(posedge bclk) disable iff (brst)
    $fell(busy_rst) |-> rd_data == 8'h00);

  a_r8_lock_hold: assert property (@(posedge bclk) disable iff (brst)
    (lock && !busy_rst) |=> rd_data == $past(rd_data));

  a_r11_ondemand: assert property (@(posedge cclk) disable iff (crst)
    core_run |-> (!$past(rd_data[7]) || $past(periph_req)));

  a_r12_standby: assert property (@(posedge cclk) disable iff (crst)
    core_run |-> (!$past(standby) || $past(rd_data[6])));
endmodule

bind cvt_ctrl_reg cvt_ctrl_reg_chk u_chk (.*);

// File: tb/test_cvt_ctrl_reg.sv
`timescale 1ns/1ps
module test_cvt_ctrl_reg;
  logic bclk = 1'b0, cclk = 1'b0;
  logic brst = 1'b1, crst = 1'b1;
  logic lock = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, busy_en, busy_rst, core_run;
  logic [7:0] rd_data;
  logic periph_req = 1'b0, standby = 1'b0;
  int n_run = 0, n_fail = 0;

  always #2   bclk = ~bclk;   // 250 MHz
  always #3.5 cclk = ~cclk;

  cvt_ctrl_reg i_cvt_ctrl_reg (.*);

  // {ondemand, runstdby, standby, req, expected run}
  localparam logic [4:0] VEC [8] = '{
    5'b0000_1, 5'b0011_0, 5'b0110_1, 5'b1000_0,
    5'b1001_1, 5'b1110_0, 5'b1111_1, 5'b1011_0
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] d);
    @(negedge bclk);
    while (!wr_ready) @(negedge bclk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bclk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && (busy_en || busy_rst); k++) @(negedge bclk);
  endtask

  task automatic wait_core(input int n);
    repeat (n) @(negedge cclk);
    @(negedge bclk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge cclk);
    @(negedge bclk); brst = 1'b0; crst = 1'b0;
    @(negedge bclk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
    chk({busy_en, busy_rst, wr_ready, core_run} == 4'b0010, "R1 flags",
        {4'h0, busy_en, busy_rst, wr_ready, core_run}, 8'h02);

    // R3/R4/R9: enable write, handshake pending
    bwrite(8'h3E);
    chk(rd_data == 8'h02, "R2 R3 readback", rd_data, 8'h02);
    chk(busy_en && !wr_ready, "R3 R9 busy_en set", {6'h0, busy_en, wr_ready}, 8'h02);
    chk(busy_rst == 1'b0, "R7 no soft reset", {7'h0, busy_rst}, 8'h00);
    @(negedge bclk);
    chk(busy_en && !core_run, "R4 still busy", {6'h0, busy_en, core_run}, 8'h02);
    wait_idle();
    chk(!busy_en && wr_ready, "R4 busy_en clears", {6'h0, busy_en, wr_ready}, 8'h01);
    wait_core(3);
    chk(core_run == 1'b1, "R4 R10 core runs", {7'h0, core_run}, 8'h01);

    // table walk over run gating
    foreach (VEC[i]) begin
      bwrite({VEC[i][4], VEC[i][3], 6'b000010});
      standby = VEC[i][2]; periph_req = VEC[i][1];
      chk(!busy_en, "R3 no handshake when enable unchanged", {7'h0, busy_en}, 8'h00);
      wait_core(4);
      chk(core_run == VEC[i][0],
          VEC[i][2] ? "R12 standby gating" : (VEC[i][4] ? "R11 on-demand" : "R10 always on"),
          {7'h0, core_run}, {7'h0, VEC[i][0]});
    end
    standby = 1'b0; periph_req = 1'b0;

    // R8: locked write dropped
    bwrite(8'h42);
    wait_idle();
    lock = 1'b1;
    bwrite(8'h80);
    bwrite(8'h01);
    chk(rd_data == 8'h42, "R8 lock readback", rd_data, 8'h42);
    chk(!busy_en && !busy_rst, "R8 lock busy", {6'h0, busy_en, busy_rst}, 8'h00);
    lock = 1'b0;

    // R5/R6: soft reset discards other bits
    bwrite(8'hBD);
    chk(rd_data == 8'h43, "R5 discard others", rd_data, 8'h43);
    chk(busy_rst && !wr_ready, "R6 R9 busy_rst set", {6'h0, busy_rst, wr_ready}, 8'h02);
    wait_idle();
    chk(rd_data == 8'h00 && !busy_rst, "R6 cleared", rd_data, 8'h00);
    wait_core(3);
    chk(core_run == 1'b0, "R6 core disabled", {7'h0, core_run}, 8'h00);

    // R7: bit 0 low is a normal write
    bwrite(8'h40);
    chk(rd_data == 8'h40 && !busy_rst, "R7 plain write", rd_data, 8'h40);

    // R3/R4: disable path
    bwrite(8'h02);
    wait_idle();
    wait_core(3);
    chk(core_run == 1'b1, "R4 re-enabled run", {7'h0, core_run}, 8'h01);
    bwrite(8'h00);
    chk(busy_en == 1'b1, "R3 busy on disable", {7'h0, busy_en}, 8'h01);
    wait_idle();
    wait_core(3);
    chk(core_run == 1'b0, "R4 disabled stops", {7'h0, core_run}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule